// File: doc/BRIEF.md
# Removable Token Power Sequencer

This block sits in a host between a removable serial memory token and the SPI master that talks to it. It watches the token's active-low presence contact. That contact closes to ground only when the token is fully seated and opens first on removal. The block filters the contact for bounce and waits for the insertion to settle. Only then does it switch on one enable that feeds both the token supply and its signal pull-ups.

Once power is on, the block waits a stabilisation interval and then asks an external contact-integrity test to run. After that it offers a transfer window to the SPI master through a request/go/done handshake. A write transfer is followed by a presence check and a verify handshake. Every session ends with power removed and a safe-to-remove indication shown until the token leaves.

Any fault latches an error code until software acknowledges it. Faults are loss of presence while powered, a failed integrity test, or a verify mismatch.

Top module: `token_pwr_seq`

## Requirements
- R1: A presence change on `tok_present_n` that lasts fewer than DEB_CYC clock cycles after synchronisation is ignored: while idle such a glitch never raises `tok_pwr_en` or `safe_remove`.
- R2: `tok_pwr_en` rises only after the debounced presence has been followed by SETTLE_CYC consecutive cycles of synchronised presence. Any cycle of synchronised absence during settling restarts the count.
- R3: After `tok_pwr_en` rises, `itest_go` rises exactly STAB_CYC cycles later, and `xfer_go` stays low until the integrity test passes. A failed test (`itest_done` with `itest_ok`=0) drops power and latches `err_code`=2.
- R4: `tok_pwr_en` is the only power control. It is high in every state where the token may be driven, so `itest_go`, `host_ready`, `xfer_go` and `vfy_go` are never high without it.
- R5: While `host_ready` is high, a `xfer_req` starts a transfer. `xfer_go` and the activity output `xfer_act` then stay high on every cycle until `xfer_done`, and both drop on the cycle after it.
- R6: If the token goes missing after a write transfer completes, and before power is removed, the block raises `err_code`=1 and never reports a completed session.
- R7: A write transfer is followed by `vfy_go`. A pass (`vfy_ok`=1) removes power and raises `safe_remove` with no error. A mismatch removes power and latches `err_code`=3. `safe_remove` is never high with power on.
- R8: A read transfer (`xfer_wr`=0) skips verification: power is removed and `safe_remove` rises on the cycle after `xfer_done`, with `vfy_go` never asserted.
- R9: Loss of synchronised presence in any powered state drops `tok_pwr_en` and every go signal on the next clock and latches `err_code`=1. This happens no more than three cycles after the pin opens.
- R10: `err_flag` and `err_code` (0 none, 1 removed, 2 integrity, 3 verify) hold until `err_ack`. The ack clears them. The block then shows `safe_remove` until debounced absence returns it to idle.
- R11: After reset all outputs are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_present_n | input | 1 | Raw presence contact, low when token seated |
| itest_done | input | 1 | Integrity test finished (one-cycle pulse) |
| itest_ok | input | 1 | Integrity test result, valid with itest_done |
| xfer_req | input | 1 | SPI master requests a transfer |
| xfer_wr | input | 1 | Requested transfer is a write, sampled with xfer_req |
| xfer_done | input | 1 | SPI master finished the transfer (pulse) |
| vfy_done | input | 1 | Verify step finished (pulse) |
| vfy_ok | input | 1 | Verify result, valid with vfy_done |
| err_ack | input | 1 | Acknowledge and clear a latched error |
| tok_pwr_en | output | 1 | Enable for token supply and pull-up supply |
| itest_go | output | 1 | Run the contact-integrity test |
| xfer_go | output | 1 | Transfer window granted to the SPI master |
| xfer_act | output | 1 | Activity indicator during a transfer |
| vfy_go | output | 1 | Run the post-write verify |
| host_ready | output | 1 | Powered, tested, waiting for a request |
| safe_remove | output | 1 | Power is off; token may be pulled |
| err_flag | output | 1 | An error is latched |
| err_code | output | 2 | Latched error cause |

## Verification
The assertions watch, on every cycle, that no go signal or ready indication appears without power and that power never comes up without presence. They also check that synchronised loss of presence cuts power with an error on the next cycle, and that a latched error and the activity output hold as required. Exact interval lengths need the bench's scenario sweep over every session outcome and every removal point: settling with restarts, the stabilisation count, the read versus write paths and verify results. The same holds for the glitch rejection and the return to idle after an acknowledge.

// File: rtl/tps_pkg.sv
package tps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_STAB,
        ST_ITEST,
        ST_READY,
        ST_XFER,
        ST_PCHK,
        ST_VERIFY,
        ST_FAULT,
        ST_RELEASE
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_REMOVED = 2'd1,
        ERR_INTEG   = 2'd2,
        ERR_VERIFY  = 2'd3
    } seq_err_e;

    typedef struct packed {
        logic pwr;
        logic itest;
        logic xfer;
        logic vfy;
        logic ready;
        logic release_ok;
    } seq_drive_t;

    function automatic logic is_powered(seq_state_e s);
        return (s == ST_STAB) || (s == ST_ITEST) || (s == ST_READY) ||
               (s == ST_XFER) || (s == ST_PCHK)  || (s == ST_VERIFY);
    endfunction

    function automatic seq_drive_t drive_of(seq_state_e s);
        seq_drive_t d;
        d.pwr        = is_powered(s);
        d.itest      = (s == ST_ITEST);
        d.xfer       = (s == ST_XFER);
        d.vfy        = (s == ST_VERIFY);
        d.ready      = (s == ST_READY);
        d.release_ok = (s == ST_RELEASE);
        return d;
    endfunction

endpackage

// File: rtl/tps_presence_filter.sv
module tps_presence_filter #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pres_sync,
    output logic pres_filt
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic          meta_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q    <= 1'b0;
            pres_sync <= 1'b0;
            pres_filt <= 1'b0;
            run_q     <= '0;
        end else begin
            meta_q    <= ~pin_n;
            pres_sync <= meta_q;
            if (pres_sync == pres_filt) begin
                run_q <= '0;
            end else if (run_q == CW'(DEB_CYC - 1)) begin
                pres_filt <= pres_sync;
                run_q     <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tps_interval_timer.sv
module tps_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] lim,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tps_seq_ctrl.sv
module tps_seq_ctrl
    import tps_pkg::*;
#(
    parameter int SETTLE_CYC = 1000,
    parameter int STAB_CYC   = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pres_sync,
    input  logic       pres_filt,
    input  logic       itest_done,
    input  logic       itest_ok,
    input  logic       xfer_req,
    input  logic       xfer_wr,
    input  logic       xfer_done,
    input  logic       vfy_done,
    input  logic       vfy_ok,
    input  logic       err_ack,
    output seq_drive_t drv,
    output seq_err_e   err
);
    localparam int MAXC = (SETTLE_CYC > STAB_CYC) ? SETTLE_CYC : STAB_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    seq_state_e st_q, st_n;
    seq_err_e   err_q, err_n;
    logic       wr_q;
    logic       t_clr, t_en, t_done;
    logic [TW-1:0] t_lim;

    assign t_lim = (st_q == ST_SETTLE) ? TW'(SETTLE_CYC - 1) : TW'(STAB_CYC - 1);
    assign t_en  = (st_q == ST_SETTLE) || (st_q == ST_STAB);
    assign t_clr = (st_n != st_q) || ((st_q == ST_SETTLE) && !pres_sync);

    tps_interval_timer #(.W(TW)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (t_clr),
        .en   (t_en),
        .lim  (t_lim),
        .done (t_done)
    );

    always_comb begin
        st_n  = st_q;
        err_n = err_q;
        unique case (st_q)
            ST_IDLE:    if (pres_filt) st_n = ST_SETTLE;
            ST_SETTLE: begin
                if (!pres_filt)                st_n = ST_IDLE;
                else if (pres_sync && t_done)  st_n = ST_STAB;
            end
            ST_STAB:    if (t_done) st_n = ST_ITEST;
            ST_ITEST: begin
                if (itest_done) begin
                    if (itest_ok) st_n = ST_READY;
                    else begin
                        st_n  = ST_FAULT;
                        err_n = ERR_INTEG;
                    end
                end
            end
            ST_READY:   if (xfer_req) st_n = ST_XFER;
            ST_XFER:    if (xfer_done) st_n = wr_q ? ST_PCHK : ST_RELEASE;
            ST_PCHK: begin
                if (pres_sync) st_n = ST_VERIFY;
                else begin
                    st_n  = ST_FAULT;
                    err_n = ERR_REMOVED;
                end
            end
            ST_VERIFY: begin
                if (vfy_done) begin
                    if (vfy_ok) st_n = ST_RELEASE;
                    else begin
                        st_n  = ST_FAULT;
                        err_n = ERR_VERIFY;
                    end
                end
            end
            ST_FAULT: begin
                if (err_ack) begin
                    st_n  = ST_RELEASE;
                    err_n = ERR_NONE;
                end
            end
            ST_RELEASE: if (!pres_filt) st_n = ST_IDLE;
            default:    st_n = ST_IDLE;
        endcase
        if (is_powered(st_q) && !pres_sync) begin
            st_n  = ST_FAULT;
            err_n = ERR_REMOVED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            err_q <= ERR_NONE;
            wr_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            err_q <= err_n;
            if (st_q == ST_READY && xfer_req) wr_q <= xfer_wr;
        end
    end

    assign drv = drive_of(st_q);
    assign err = err_q;
endmodule

// File: rtl/token_pwr_seq.sv
module token_pwr_seq
    import tps_pkg::*;
#(
    parameter int DEB_CYC    = 16,
    parameter int SETTLE_CYC = 1000,
    parameter int STAB_CYC   = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tok_present_n,
    input  logic       itest_done,
    input  logic       itest_ok,
    input  logic       xfer_req,
    input  logic       xfer_wr,
    input  logic       xfer_done,
    input  logic       vfy_done,
    input  logic       vfy_ok,
    input  logic       err_ack,
    output logic       tok_pwr_en,
    output logic       itest_go,
    output logic       xfer_go,
    output logic       xfer_act,
    output logic       vfy_go,
    output logic       host_ready,
    output logic       safe_remove,
    output logic       err_flag,
    output logic [1:0] err_code
);
    logic       pres_sync, pres_filt;
    seq_drive_t drv;
    seq_err_e   err;

    tps_presence_filter #(.DEB_CYC(DEB_CYC)) u_flt (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (tok_present_n),
        .pres_sync (pres_sync),
        .pres_filt (pres_filt)
    );

    tps_seq_ctrl #(.SETTLE_CYC(SETTLE_CYC), .STAB_CYC(STAB_CYC)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .pres_sync  (pres_sync),
        .pres_filt  (pres_filt),
        .itest_done (itest_done),
        .itest_ok   (itest_ok),
        .xfer_req   (xfer_req),
        .xfer_wr    (xfer_wr),
        .xfer_done  (xfer_done),
        .vfy_done   (vfy_done),
        .vfy_ok     (vfy_ok),
        .err_ack    (err_ack),
        .drv        (drv),
        .err        (err)
    );

    assign tok_pwr_en  = drv.pwr;
    assign itest_go    = drv.itest;
    assign xfer_go     = drv.xfer;
    assign xfer_act    = drv.xfer;
    assign vfy_go      = drv.vfy;
    assign host_ready  = drv.ready;
    assign safe_remove = drv.release_ok;
    assign err_code    = err;
    assign err_flag    = (err != ERR_NONE);
endmodule

// File: rtl/tps_checker.sv
module tps_checker (
    input logic clk,
    input logic rst,
    input logic pres_sync,
    input logic pres_filt,
    input logic tok_pwr_en,
    input logic itest_go,
    input logic xfer_go,
    input logic xfer_act,
    input logic vfy_go,
    input logic host_ready,
    input logic safe_remove,
    input logic err_flag,
    input logic err_ack,
    input logic xfer_done
);
    // R4
    go_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
        (itest_go || xfer_go || vfy_go || host_ready) |-> tok_pwr_en);

    // R2
    power_rise_needs_presence_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tok_pwr_en) |-> (pres_filt && pres_sync));

    // R9
    loss_drops_power_chk: assert property (@(posedge clk) disable iff (rst)
        (tok_pwr_en && !pres_sync) |=> (!tok_pwr_en && err_flag));

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_ack) |=> err_flag);

    // R5
    activity_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && !xfer_done && pres_sync) |=> (xfer_act && xfer_go));

    // R7
    safe_no_power_chk: assert property (@(posedge clk) disable iff (rst)
        safe_remove |-> !tok_pwr_en);
endmodule

bind token_pwr_seq tps_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .pres_sync   (pres_sync),
    .pres_filt   (pres_filt),
    .tok_pwr_en  (tok_pwr_en),
    .itest_go    (itest_go),
    .xfer_go     (xfer_go),
    .xfer_act    (xfer_act),
    .vfy_go      (vfy_go),
    .host_ready  (host_ready),
    .safe_remove (safe_remove),
    .err_flag    (err_flag),
    .err_ack     (err_ack),
    .xfer_done   (xfer_done)
);

// File: tb/sim_token_pwr_seq.sv
`timescale 1ns/100ps
module sim_token_pwr_seq;
    localparam int DEB = 4;
    localparam int SET = 16;
    localparam int STB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tok_present_n = 1'b1;
    logic itest_done = 0, itest_ok = 0, xfer_req = 0, xfer_wr = 0;
    logic xfer_done = 0, vfy_done = 0, vfy_ok = 0, err_ack = 0;
    logic tok_pwr_en, itest_go, xfer_go, xfer_act, vfy_go;
    logic host_ready, safe_remove, err_flag;
    logic [1:0] err_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done_run = 0;

    always #2.5 clk = ~clk;

    token_pwr_seq #(.DEB_CYC(DEB), .SETTLE_CYC(SET), .STAB_CYC(STB)) u0 (
        .clk(clk), .rst(rst), .tok_present_n(tok_present_n),
        .itest_done(itest_done), .itest_ok(itest_ok),
        .xfer_req(xfer_req), .xfer_wr(xfer_wr), .xfer_done(xfer_done),
        .vfy_done(vfy_done), .vfy_ok(vfy_ok), .err_ack(err_ack),
        .tok_pwr_en(tok_pwr_en), .itest_go(itest_go), .xfer_go(xfer_go),
        .xfer_act(xfer_act), .vfy_go(vfy_go), .host_ready(host_ready),
        .safe_remove(safe_remove), .err_flag(err_flag), .err_code(err_code)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wait_pwr(output int n);
        n = 0;
        while (!tok_pwr_en && n < 300) begin
            step();
            n++;
        end
    endtask

    task automatic expect_fault(input int code, input string req);
        int n = 0;
        while (!err_flag && n < 8) begin
            step();
            n++;
        end
        chk(err_flag && err_code == code, req, err_code, code);
        // R9: fault reaction time and all outputs quiet
        chk(n <= 3, "R9", n, 3);
        chk(!tok_pwr_en && !xfer_go && !vfy_go && !itest_go && !xfer_act, "R9",
            tok_pwr_en, 0);
        for (int k = 0; k < 4; k++) step();
        chk(err_flag && err_code == code, "R10", err_code, code);
        err_ack = 1;
        step();
        err_ack = 0;
        chk(!err_flag && err_code == 0, "R10", err_code, 0);
    endtask

    task automatic to_idle();
        int n = 0;
        tok_present_n = 1;
        while ((safe_remove || tok_pwr_en) && n < 30) begin
            step();
            n++;
        end
        for (int k = 0; k < 3; k++) step();
        chk(!safe_remove && !tok_pwr_en && !err_flag && !host_ready, "R10",
            safe_remove, 0);
    endtask

    // m: 0 read, 1 write ok, 2 verify fail, 3 integrity fail,
    //    4 pull in stabilise, 5 pull while ready, 6 pull mid-transfer,
    //    7 pull at write completion
    task automatic session(input int m);
        int n;
        bit saw_x;
        tok_present_n = 0;
        wait_pwr(n);
        chk(n >= DEB + SET && n <= DEB + SET + 6, "R2", n, DEB + SET + 3);
        if (m == 4) begin
            step(); step(); step();
            tok_present_n = 1;
            expect_fault(1, "R9");
            to_idle();
            return;
        end
        xfer_req = 1;
        xfer_wr  = 1;
        n = 0;
        saw_x = 0;
        while (!itest_go && n < 40) begin
            if (xfer_go) saw_x = 1;
            chk(tok_pwr_en, "R4", tok_pwr_en, 1);
            step();
            n++;
        end
        chk(n == STB, "R3", n, STB);
        chk(!saw_x, "R3", saw_x, 0);
        xfer_req = 0;
        step(); step();
        chk(itest_go && !xfer_go, "R3", xfer_go, 0);
        itest_done = 1;
        itest_ok   = (m != 3);
        step();
        itest_done = 0;
        if (m == 3) begin
            expect_fault(2, "R3");
            chk(safe_remove, "R10", safe_remove, 1);
            to_idle();
            return;
        end
        chk(host_ready && tok_pwr_en, "R5", host_ready, 1);
        if (m == 5) begin
            tok_present_n = 1;
            expect_fault(1, "R9");
            to_idle();
            return;
        end
        xfer_req = 1;
        xfer_wr  = (m != 0);
        step();
        xfer_req = 0;
        chk(xfer_go && xfer_act && !host_ready, "R5", xfer_act, 1);
        for (int k = 0; k < 4; k++) begin
            step();
            chk(xfer_go && xfer_act && tok_pwr_en, "R5", xfer_act, 1);
        end
        if (m == 6) begin
            tok_present_n = 1;
            expect_fault(1, "R9");
            to_idle();
            return;
        end
        if (m == 7) begin
            tok_present_n = 1;
            xfer_done = 1;
            step();
            xfer_done = 0;
            expect_fault(1, "R6");
            to_idle();
            return;
        end
        xfer_done = 1;
        step();
        xfer_done = 0;
        chk(!xfer_act && !xfer_go, "R5", xfer_act, 0);
        if (m == 0) begin
            chk(safe_remove && !tok_pwr_en && !vfy_go && !err_flag, "R8",
                safe_remove, 1);
            to_idle();
            return;
        end
        step();
        chk(vfy_go && tok_pwr_en, "R7", vfy_go, 1);
        step(); step();
        vfy_done = 1;
        vfy_ok   = (m != 2);
        step();
        vfy_done = 0;
        if (m == 2) begin
            expect_fault(3, "R7");
            chk(safe_remove, "R10", safe_remove, 1);
        end else begin
            chk(safe_remove && !tok_pwr_en && !err_flag, "R7", safe_remove, 1);
            chk(err_code == 0, "R7", err_code, 0);
        end
        to_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int n;
        step(); step();
        rst = 0;
        step();
        // R11
        chk(!tok_pwr_en && !itest_go && !xfer_go && !xfer_act && !vfy_go,
            "R11", tok_pwr_en, 0);
        chk(!host_ready && !safe_remove && !err_flag && err_code == 0,
            "R11", err_code, 0);

        // R1: glitches shorter than the filter window while idle
        for (int g = 1; g < DEB; g++) begin
            tok_present_n = 0;
            for (int k = 0; k < g; k++) step();
            tok_present_n = 1;
            n = 0;
            for (int k = 0; k < 40; k++) begin
                if (tok_pwr_en || safe_remove) n++;
                step();
            end
            chk(n == 0, "R1", n, 0);
        end

        // R2: bounce during settling restarts the settle count
        tok_present_n = 0;
        for (int k = 0; k < 10; k++) step();
        for (int b = 0; b < 3; b++) begin
            tok_present_n = 1;
            step(); step();
            tok_present_n = 0;
            for (int k = 0; k < 5; k++) begin
                chk(!tok_pwr_en, "R2", tok_pwr_en, 0);
                step();
            end
        end
        wait_pwr(n);
        n = n + 5;
        chk(n >= SET && n <= SET + 4, "R2", n, SET + 2);
        tok_present_n = 1;
        expect_fault(1, "R9");
        to_idle();

        // sweep every session outcome and removal point
        for (int m = 0; m < 8; m++) session(m);
        for (int m = 0; m < 8; m++) session(7 - m);

        finish_run();
    end
endmodule